// File: doc/BRIEF.md
# Software (Xon/Xoff) Flow Controller for One Serial Channel

The block applies in-band flow control to a single serial channel. On the receive path it looks at every character the deserializer delivers, together with an error indication. It then decides whether the character is a flow token that stops or restarts the local transmitter, or ordinary data to be written to the receive FIFO. On the transmit path it compares the receive FIFO fill level with a halt threshold and a resume threshold. When a threshold is crossed, it asks the transmitter to insert stop or restart tokens between data characters.

A 4-bit mode input selects which of four programmable characters (two restart tokens, two stop tokens) are sent and recognised. Tokens are used either singly or as a two-character sequence. The block also has three further features:
- Resume-on-any-character, which lets any received character restart a halted transmitter.
- A special-character detector, which raises an interrupt flag without stopping the transmitter.
- An automatic restart token, sent when the mode is changed after a stop token has gone out.

Received characters are assumed never to arrive on two consecutive clock cycles, because the serial line delivers them many cycles apart.

Top module: `swfc_ctrl`

## Requirements
- R1: After reset, `tx_halt`, `xoff_irq`, `wr_en` and `inj_req` are all low.
- R2: A received character that is not consumed as a flow token is written to the FIFO. `wr_en` is high with `wr_data` equal to that character on the cycle after `rx_valid`.
- R3: Single-token receive modes:
  - `mode[1:0]`=10 compares against `xon1`/`xoff1`, and `mode[1:0]`=01 compares against `xon2`/`xoff2`.
  - A matching stop token sets `tx_halt` and `xoff_irq` on the next cycle. A matching restart token clears both.
  - A token consumed in this way is not written.
- R4: With `mode[1:0]`=11 and `mode[3:2]` equal to 10 or 01, either stop character (`xoff1` or `xoff2`) halts, and either restart character resumes.
- R5: Pair receive mode (`mode[1:0]`=11 and `mode[3:2]` equal to 11 or 00):
  - Only `xoff1` followed by `xoff2`, or `xon1` followed by `xon2`, acts; the first character of a pair is held back.
  - If the next character is not the matching second token, the held character is written first. The new character is written one cycle later, unless it is itself a first token, in which case it is held in turn.
- R6: A character received with `rx_err` high is always stored as data and has no flow effect.
- R7: With `resume_any` high, a halted transmitter is released by any received character that is not a stop token and is not held as a pair start. That character is stored if it is data.
- R8: Special-character detection:
  - With `special_en` high, an error-free character equal to `xoff2` sets `xoff_irq`, is stored, and does not halt the transmitter, even in modes where it is a stop token.
  - A pulse on `isr_read` clears that flag.
- R9: With `mode[1:0]`=00 no character is compared, and `tx_halt` is released on the next cycle.
- R10: When no stop token is outstanding, `mode[3:2]` is not 00, and `fifo_level` is at least 4*`halt_lvl`, the block requests a stop-token injection:
  - The tokens sent depend on `mode[3:2]`: 10 sends `xoff1`, 01 sends `xoff2`, and 11 sends `xoff1` then `xoff2`.
  - `inj_req` stays high with a steady `inj_char` until `inj_ack`.
  - The second character of a pair is requested on the cycle after the first acknowledge.
- R11: Once a stop token has been sent, the restart tokens of that same token set are requested when `fifo_level` is at most 4*`resume_lvl`.
- R12: If `mode[3:2]` changes after a stop token was sent, the restart tokens of the old set are injected. If the level is still at least 4*`halt_lvl`, the stop tokens of the new set then follow.
- R13: `inj_char` keeps only the low 5, 6, 7 or 8 bits of the token, for `word_len` = 00, 01, 10 or 11 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 4 | [3:2] transmit token set, [1:0] receive compare set |
| resume_any | input | 1 | Any received character releases a halt |
| special_en | input | 1 | Enable special-character detection on `xoff2` |
| xon1 | input | 8 | First restart character |
| xon2 | input | 8 | Second restart character |
| xoff1 | input | 8 | First stop character |
| xoff2 | input | 8 | Second stop character / special character |
| word_len | input | 2 | Character length, 00=5 bits to 11=8 bits |
| halt_lvl | input | 4 | Halt threshold, in units of four entries |
| resume_lvl | input | 4 | Resume threshold, in units of four entries |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| rx_err | input | 1 | Parity, framing or break error on this character |
| isr_read | input | 1 | Interrupt identification read pulse |
| fifo_level | input | LW | Receive FIFO fill level |
| inj_ack | input | 1 | Transmitter took the injected character |
| tx_halt | output | 1 | Hold the transmitter at the next character boundary |
| xoff_irq | output | 1 | Stop-token / special-character interrupt flag |
| wr_en | output | 1 | Write strobe to the receive FIFO |
| wr_data | output | 8 | Character to write |
| inj_req | output | 1 | Flow-character injection request |
| inj_char | output | 8 | Character to inject, truncated to the word length |

## Verification
The bench goes after the following corner cases:
- **A broken pair in pair mode.** A design that drops the held first token loses a data byte. One that writes both characters in the same cycle overwrites one of them.
- **A stop token received with an error flag.** A design that ignores the error stalls the link on noise.
- **Special-character priority over a stop token.** Getting this wrong halts the transmitter when only an interrupt was wanted.
- **A mode change after a stop token was sent.** A design that does not resend the old restart token leaves the far end stopped for good.
- **The halt threshold at exactly 4*`halt_lvl`, and a 5-bit truncation of an injected token.** These expose off-by-one and masking mistakes as a missing or corrupted request.

// File: rtl/swfc_ctrl.sv
module swfc_ctrl #(
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    mode,
  input  logic          resume_any,
  input  logic          special_en,
  input  logic [7:0]    xon1,
  input  logic [7:0]    xon2,
  input  logic [7:0]    xoff1,
  input  logic [7:0]    xoff2,
  input  logic [1:0]    word_len,
  input  logic [3:0]    halt_lvl,
  input  logic [3:0]    resume_lvl,
  input  logic          rx_valid,
  input  logic [7:0]    rx_char,
  input  logic          rx_err,
  input  logic          isr_read,
  input  logic [LW-1:0] fifo_level,
  input  logic          inj_ack,
  output logic          tx_halt,
  output logic          xoff_irq,
  output logic          wr_en,
  output logic [7:0]    wr_data,
  output logic          inj_req,
  output logic [7:0]    inj_char
);

  wire [1:0] rm = mode[1:0];
  wire [1:0] tm = mode[3:2];

  logic       pend, pend_off, stash_v, spec_flag;
  logic [7:0] pend_c, stash_d;

  wire pair_rx = rm == 2'b11 && (tm == 2'b11 || tm == 2'b00);
  wire either  = rm == 2'b11 && !pair_rx;
  wire ok      = rx_valid && !rx_err;
  wire spec    = ok && special_en && rx_char == xoff2;
  wire tok_ok  = ok && !spec;

  wire hit_off = ((rm == 2'b10 || either) && rx_char == xoff1) ||
                 ((rm == 2'b01 || either) && rx_char == xoff2);
  wire hit_on  = ((rm == 2'b10 || either) && rx_char == xon1) ||
                 ((rm == 2'b01 || either) && rx_char == xon2);

  wire pair_done = tok_ok && pair_rx && pend && rx_char == (pend_off ? xoff2 : xon2);
  wire keep      = tok_ok && pair_rx && !pair_done && (rx_char == xon1 || rx_char == xoff1);
  wire act_off   = pair_rx ? (pair_done && pend_off)  : (tok_ok && hit_off);
  wire act_on    = pair_rx ? (pair_done && !pend_off) : (tok_ok && hit_on);
  wire store     = rx_valid && !keep && !act_on && !act_off;
  wire flush     = rx_valid && pend && !pair_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_halt <= 1'b0; spec_flag <= 1'b0; wr_en <= 1'b0; wr_data <= 8'h00;
      pend <= 1'b0; pend_off <= 1'b0; pend_c <= 8'h00;
      stash_v <= 1'b0; stash_d <= 8'h00;
    end else begin
      wr_en <= 1'b0;
      if (stash_v) begin
        wr_en <= 1'b1; wr_data <= stash_d; stash_v <= 1'b0;
      end
      if (isr_read) spec_flag <= 1'b0;
      if (rx_valid) begin
        if (spec) spec_flag <= 1'b1;
        if (flush) begin
          wr_en <= 1'b1; wr_data <= pend_c;
          stash_v <= store; stash_d <= rx_char;
        end else if (store) begin
          wr_en <= 1'b1; wr_data <= rx_char;
        end
        pend <= keep;
        if (keep) begin
          pend_c <= rx_char; pend_off <= rx_char != xon1;
        end
        if (act_off) tx_halt <= 1'b1;
        else if (act_on || (resume_any && !keep)) tx_halt <= 1'b0;
      end
      if (rm == 2'b00) tx_halt <= 1'b0;
    end
  end

  assign xoff_irq = tx_halt | spec_flag;

  wire [LW-1:0] h_th  = LW'({halt_lvl, 2'b00});
  wire [LW-1:0] r_th  = LW'({resume_lvl, 2'b00});
  wire [7:0]    wmask = 8'hFF >> (2'd3 - word_len);

  logic       busy, kind, idx, xs;
  logic [1:0] stm, run;

  wire xon_need  = xs && (fifo_level <= r_th || tm != stm);
  wire xoff_need = !xs && tm != 2'b00 && fifo_level >= h_th;
  wire sec       = run == 2'b01 || (run == 2'b11 && idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; kind <= 1'b0; idx <= 1'b0; xs <= 1'b0;
      stm <= 2'b00; run <= 2'b00;
    end else if (!busy) begin
      if (xon_need) begin
        busy <= 1'b1; kind <= 1'b0; run <= stm; idx <= 1'b0;
      end else if (xoff_need) begin
        busy <= 1'b1; kind <= 1'b1; run <= tm; idx <= 1'b0;
      end
    end else if (inj_ack) begin
      if (run == 2'b11 && !idx) idx <= 1'b1;
      else begin
        busy <= 1'b0;
        if (kind) begin xs <= 1'b1; stm <= run; end
        else xs <= 1'b0;
      end
    end
  end

  assign inj_req  = busy;
  assign inj_char = (kind ? (sec ? xoff2 : xoff1) : (sec ? xon2 : xon1)) & wmask;

  AST_ERR_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_err |=> wr_en); // R6
  AST_HALT_FROM_RX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_halt) |-> $past(rx_valid)); // R3
  AST_SPEC_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_err && special_en && rx_char == xoff2 |=> !$rose(tx_halt)); // R8
  AST_ISR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    isr_read && !rx_valid |=> !xoff_irq || tx_halt); // R8
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    inj_req && !inj_ack |=> inj_req); // R10

endmodule

// File: tb/tb_swfc_ctrl.sv
module tb_swfc_ctrl;
  localparam int CLKP = 10;

  logic clk = 0, rst_n = 0;
  logic [3:0] mode = 0;
  logic resume_any = 0, special_en = 0;
  logic [7:0] xon1 = 8'h11, xon2 = 8'h12, xoff1 = 8'h13, xoff2 = 8'h14;
  logic [1:0] word_len = 2'b11;
  logic [3:0] halt_lvl = 4'hF, resume_lvl = 4'h8;
  logic rx_valid = 0, rx_err = 0, isr_read = 0, inj_ack = 0;
  logic [7:0] rx_char = 0;
  logic [6:0] fifo_level = 0;
  logic tx_halt, xoff_irq, wr_en, inj_req;
  logic [7:0] wr_data, inj_char;

  swfc_ctrl dut (.*);

  always #(CLKP/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  bit m_halt, m_spec, m_pend, m_poff, m_xs, m_kind;
  bit [1:0] m_stm, m_run;
  bit [7:0] m_pc;
  byte unsigned wq[$];
  byte unsigned tq[$];
  bit exp_wr, exp_req;
  bit [7:0] exp_wd, exp_ic;

  function automatic bit [7:0] msk(bit [7:0] c);
    return c & (8'hFF >> (3 - word_len));
  endfunction

  task automatic push_tok(bit [1:0] set, bit off);
    if (set[1]) tq.push_back(msk(off ? xoff1 : xon1));
    if (set[0]) tq.push_back(msk(off ? xoff2 : xon2));
  endtask

  task automatic model_step();
    bit [1:0] rm, tm;
    bit pr, ei, ok, sp, on, off, kp;
    bit [7:0] c;
    if (!rst_n) begin
      m_halt = 0; m_spec = 0; m_pend = 0; m_xs = 0; wq.delete(); tq.delete();
      exp_wr = 0; exp_req = 0;
      return;
    end
    rm = mode[1:0]; tm = mode[3:2];
    pr = rm == 3 && (tm == 3 || tm == 0);
    ei = rm == 3 && !pr;
    if (isr_read) m_spec = 0;
    if (rx_valid) begin
      ok = !rx_err; c = rx_char; sp = ok && special_en && c == xoff2;
      on = 0; off = 0; kp = 0;
      if (sp) m_spec = 1;
      if (ok && !sp) begin
        if (pr) begin
          if (m_pend && c == (m_poff ? xoff2 : xon2)) begin
            if (m_poff) off = 1; else on = 1;
          end else if (c == xon1 || c == xoff1) kp = 1;
        end else begin
          if (((rm == 2 || ei) && c == xoff1) || ((rm == 1 || ei) && c == xoff2)) off = 1;
          if (((rm == 2 || ei) && c == xon1) || ((rm == 1 || ei) && c == xon2)) on = 1;
        end
      end
      if (m_pend && !(pr && (on || off))) wq.push_back(m_pc);
      if (!(on || off || kp)) wq.push_back(c);
      m_pend = kp;
      if (kp) begin m_pc = c; m_poff = c != xon1; end
      if (off) m_halt = 1;
      else if (on || (resume_any && !kp)) m_halt = 0;
    end
    if (rm == 0) m_halt = 0;
    exp_wr = wq.size() > 0;
    if (exp_wr) exp_wd = wq.pop_front();
    if (tq.size() == 0) begin
      if (m_xs && (int'(fifo_level) <= 4*resume_lvl || tm != m_stm)) begin
        push_tok(m_stm, 0); m_kind = 0; m_run = m_stm;
      end else if (!m_xs && tm != 0 && int'(fifo_level) >= 4*halt_lvl) begin
        push_tok(tm, 1); m_kind = 1; m_run = tm;
      end
    end else if (inj_ack) begin
      void'(tq.pop_front());
      if (tq.size() == 0) begin
        if (m_kind) begin m_xs = 1; m_stm = m_run; end
        else m_xs = 0;
      end
    end
    exp_req = tq.size() > 0;
    if (exp_req) exp_ic = tq[0];
  endtask

  task automatic chk(string nm, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", cur_req, nm, act, exp);
    end
  endtask

  always @(posedge clk) begin
    model_step();
    #(CLKP/4);
    chk("tx_halt", tx_halt, m_halt);
    chk("xoff_irq", xoff_irq, m_halt | m_spec);
    chk("wr_en", wr_en, exp_wr);
    if (exp_wr) chk("wr_data", wr_data, exp_wd);
    chk("inj_req", inj_req, exp_req);
    if (exp_req) chk("inj_char", inj_char, exp_ic);
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog %s act=hung exp=done", cur_req);
    summary();
    $finish;
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic [3:0] m);
    @(negedge clk);
    rst_n = 0; mode = m; fifo_level = 0;
    idle(2);
    rst_n = 1;
    idle(1);
  endtask

  task automatic rx(logic [7:0] c, logic e);
    @(negedge clk);
    rx_valid = 1; rx_char = c; rx_err = e;
    @(negedge clk);
    rx_valid = 0; rx_err = 0;
    idle(3);
  endtask

  task automatic ack_one();
    for (int i = 0; i < 50 && !inj_req; i++) @(negedge clk);
    idle(2);
    inj_ack = 1;
    @(negedge clk);
    inj_ack = 0;
    idle(1);
  endtask

  initial begin
    cur_req = "R1"; do_reset(4'b0000); idle(3);

    cur_req = "R2"; do_reset(4'b1010); rx(8'h41, 0); rx(8'h7E, 0);
    cur_req = "R3"; rx(8'h13, 0); rx(8'h42, 0); rx(8'h11, 0);
    mode = 4'b0101; rx(8'h14, 0); rx(8'h13, 0); rx(8'h12, 0);

    cur_req = "R4"; do_reset(4'b1011); rx(8'h14, 0); rx(8'h11, 0);
    rx(8'h13, 0); rx(8'h12, 0);

    cur_req = "R5"; do_reset(4'b1111);
    rx(8'h13, 0); rx(8'h14, 0);
    rx(8'h11, 0); rx(8'h55, 0);
    rx(8'h11, 0); rx(8'h13, 0); rx(8'h12, 0);
    rx(8'h11, 0); rx(8'h12, 0);
    mode = 4'b0011; rx(8'h13, 0); rx(8'h14, 0); rx(8'h11, 0); rx(8'h12, 0);

    cur_req = "R6"; do_reset(4'b1010); rx(8'h13, 1); rx(8'h11, 0); rx(8'h13, 0); rx(8'h11, 1);

    cur_req = "R7"; do_reset(4'b1010); resume_any = 1;
    rx(8'h13, 0); rx(8'h77, 0); rx(8'h13, 0); rx(8'h11, 0);
    resume_any = 0;

    cur_req = "R8"; do_reset(4'b1011); special_en = 1;
    rx(8'h14, 0); idle(2);
    @(negedge clk); isr_read = 1; @(negedge clk); isr_read = 0; idle(2);
    rx(8'h14, 1); special_en = 0;

    cur_req = "R9"; do_reset(4'b1010); rx(8'h13, 0);
    @(negedge clk); mode = 4'b1000; idle(3); rx(8'h13, 0);

    cur_req = "R10"; do_reset(4'b1000);
    fifo_level = 59; idle(4);
    fifo_level = 60; ack_one(); idle(3);
    cur_req = "R11"; fifo_level = 33; idle(3);
    fifo_level = 32; ack_one(); fifo_level = 10; idle(3);

    cur_req = "R10"; do_reset(4'b1100); fifo_level = 61;
    ack_one(); ack_one(); idle(2);
    cur_req = "R11"; fifo_level = 5; ack_one(); ack_one(); idle(3);

    cur_req = "R12"; do_reset(4'b1000); fifo_level = 62; ack_one();
    @(negedge clk); mode = 4'b0100;
    ack_one(); ack_one(); idle(2);
    @(negedge clk); mode = 4'b0000; fifo_level = 62; ack_one(); idle(4);

    cur_req = "R13"; xoff1 = 8'hF3; xon1 = 8'hE1; word_len = 2'b00;
    do_reset(4'b1000); fifo_level = 60; ack_one();
    word_len = 2'b01; fifo_level = 0; ack_one();
    word_len = 2'b10; fifo_level = 60; ack_one(); idle(2);

    summary();
    $finish;
  end
endmodule